// File: doc/BRIEF.md
# Multiprocessor Interrupt Router

This block gathers level-sensitive interrupt requests and steers them to a set of processors. There are 32 device request lines and one local timer line per processor. A fixed table, given as a parameter, gives each device bit a priority level from 0 to 15. Device requests are latched in a shared pending register and masked by a shared disable register. Every unmasked request is routed to one processor, chosen by a programmable target register.

Each processor also has its own pending register. Software can set and clear the upper half of that register, and those bits appear directly on the processor's priority lines. Each processor has fifteen output lines, one for each level from 1 to 15.

Software reaches the block through a plain 32-bit word bus. The read path is combinational. A `bus_master` select picks either the shared register block or one processor page. The page number is taken from address bits 15:12. The word index is taken from bits 4:2 in the shared block and from bits 3:2 in a processor page.

Top module: `mp_irq_router`

## Requirements
- R1: Shared block word 0 reads the pending register with bit 31 forced to 0, and word 4 reads the 4-bit target. In a processor page, word 0 reads that processor's pending register. Any other word index, including the write-only ones, reads 0. Writes to undefined indices change nothing.
- R2: Bits set in 0x0FA2007F are reserved. They are removed from every value written to the disable registers, so reserved sources stay disabled. Word 1 reads the disable register ANDed with 0xF05DFF80.
- R3: After reset, every pending register is 0, the target is 0, the disable register holds 0x0FA2007F (so word 1 reads 0), and every output line is low.
- R4: A write to shared word 2 clears the written disable bits. A write to shared word 3 sets the written disable bits and also clears the same pending bits.
- R5: A rising device line with a non-zero mapped level sets its shared pending bit. It also sets bit `level` in the pending register of the current target. A falling line clears both bits. A line whose mapped level is 0 changes nothing.
- R6: Each pending, enabled device bit drives its mapped level on the target processor only. Output bit k of a processor carries level k+1.
- R7: When disable bit 31 is set, no device level reaches any processor. Software levels are not affected.
- R8: A write to page word 2 sets the written bits within 31:17 of that processor's pending register. Pending bit n (n = 17..31) drives level n-16.
- R9: A write to page word 1 clears the written bits within 31:17. Writing bit 14 also clears bit 31. Other low bits have no effect.
- R10: A rising timer line of processor p sets shared pending bit TIMER_SRC (19) and bit `level(TIMER_SRC)` (3) in p's pending register. A falling timer line clears both bits.
- R11: A change on a line or a register write shows on the outputs after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | NSRC (32) | Level-sensitive device request lines |
| tmr_irq | input | NCPU (16) | Per-processor local timer lines |
| bus_master | input | 1 | 1 selects the shared block, 0 selects a processor page |
| bus_addr | input | ADDR_W (16) | Byte address of the word |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| lvl_out | output | NCPU*15 | Priority lines; processor i uses bits [i*15 +: 15] |

## Verification
A table of device-line patterns is applied with processor 0 as the target, using a level table in which source j maps to level j mod 16. The patterns use single sources, two sources on different levels, two sources that share one level, a level-0 source and a reserved source. Together they separate a correct level translation from a shift error, an inverted mask or a missing zero-level filter. Directed sequences then move the target between processors and raise lines while their sources are disabled. They also combine device and software levels on one processor, so the global disable can be told apart from a plain clear. Finally, they exercise the bit-14 remap against ordinary low bits that must be ignored.

// File: rtl/mpir_pkg.sv
package mpir_pkg;
   localparam int unsigned DATA_W = 32;

   typedef enum logic [2:0] {
      MW_PEND = 3'd0,
      MW_DIS  = 3'd1,
      MW_ENA  = 3'd2,
      MW_MASK = 3'd3,
      MW_TGT  = 3'd4
   } mword_e;

   typedef enum logic [1:0] {
      CW_PEND  = 2'd0,
      CW_SWCLR = 2'd1,
      CW_SWSET = 2'd2
   } cword_e;
endpackage

// File: rtl/mpir_lvl_map.sv
module mpir_lvl_map #(
   parameter int unsigned NSRC  = 32,
   parameter int unsigned LVL_W = 4,
   parameter int unsigned NLVL  = 16,
   parameter logic [NSRC*LVL_W-1:0] LVL_MAP = '0
) (
   input  logic [NSRC-1:0] src,
   output logic [NLVL-1:0] lvl
);
   always_comb begin
      lvl = '0;
      for (int j = 0; j < NSRC; j++) begin
         if (src[j]) lvl[LVL_MAP[j*LVL_W +: LVL_W]] = 1'b1;
      end
   end
endmodule

// File: rtl/mpir_master_regs.sv
module mpir_master_regs #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CPU_W  = 4,
   parameter logic [DATA_W-1:0] VALID = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_set,
   input  logic [DATA_W-1:0] src_clr,
   input  logic              ena_wr,
   input  logic              mask_wr,
   input  logic              tgt_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] pend,
   output logic [DATA_W-1:0] dis,
   output logic [CPU_W-1:0]  tgt
);
   logic [DATA_W-1:0] wmask, nxt_pend, nxt_dis;

   assign wmask = wdata & VALID;

   always_comb begin
      nxt_pend = (pend & ~src_clr) | src_set;
      nxt_dis  = dis;
      if (ena_wr) nxt_dis = nxt_dis & ~wmask;
      if (mask_wr) begin
         nxt_dis  = nxt_dis | wmask;
         nxt_pend = nxt_pend & ~wmask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         dis  <= ~VALID;
         tgt  <= '0;
      end else begin
         pend <= nxt_pend;
         dis  <= nxt_dis;
         if (tgt_wr) tgt <= wdata[CPU_W-1:0];
      end
   end
endmodule

// File: rtl/mpir_cpu_pend.sv
module mpir_cpu_pend #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OUT_W     = 15,
   parameter int unsigned REMAP_BIT = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] lvl_set,
   input  logic [DATA_W-1:0] lvl_clr,
   input  logic              sw_set_wr,
   input  logic              sw_clr_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] pend
);
   localparam logic [DATA_W-1:0] SW_MASK = {{OUT_W{1'b1}}, {(DATA_W-OUT_W){1'b0}}};

   logic [DATA_W-1:0] clr_bits, nxt;

   always_comb begin
      clr_bits = wdata & SW_MASK;
      if (wdata[REMAP_BIT]) clr_bits[DATA_W-1] = 1'b1;
      nxt = (pend & ~lvl_clr) | lvl_set;
      if (sw_clr_wr) nxt = nxt & ~clr_bits;
      if (sw_set_wr) nxt = nxt | (wdata & SW_MASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= nxt;
   end
endmodule

// File: rtl/mpir_route.sv
module mpir_route #(
   parameter int unsigned NCPU   = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LVL_W  = 4,
   parameter int unsigned NLVL   = 16,
   parameter int unsigned OUT_W  = 15,
   parameter int unsigned CPU_W  = 4,
   parameter logic [DATA_W*LVL_W-1:0] LVL_MAP = '0
) (
   input  logic [DATA_W-1:0]      mpend,
   input  logic [DATA_W-1:0]      mdis,
   input  logic [CPU_W-1:0]       tgt,
   input  logic [NCPU*DATA_W-1:0] cpu_pend_flat,
   output logic [NCPU*OUT_W-1:0]  lvl_out
);
   logic [DATA_W-1:0] eff;
   logic [NLVL-1:0]   eff_lvl;
   logic              dev_ok;

   assign eff    = mpend & ~mdis;
   assign dev_ok = (|eff) & ~mdis[DATA_W-1];

   mpir_lvl_map #(.NSRC(DATA_W), .LVL_W(LVL_W), .NLVL(NLVL), .LVL_MAP(LVL_MAP))
      u_eff_map (.src(eff), .lvl(eff_lvl));

   logic unused_lvl0;
   assign unused_lvl0 = eff_lvl[0];

   for (genvar i = 0; i < NCPU; i++) begin : g_out
      logic hit;
      assign hit = dev_ok && (int'(tgt) == i);
      assign lvl_out[i*OUT_W +: OUT_W] = (hit ? eff_lvl[NLVL-1:1] : '0)
                                       | cpu_pend_flat[i*DATA_W + DATA_W-1 -: OUT_W];
   end
endmodule

// File: rtl/mp_irq_router.sv
module mp_irq_router
   import mpir_pkg::*;
#(
   parameter int unsigned NCPU       = 16,
   parameter int unsigned NSRC       = 32,
   parameter int unsigned LVL_W      = 4,
   parameter logic [NSRC*LVL_W-1:0] LVL_MAP = 128'hFEDCBA9876543210_FEDCBA9876543210,
   parameter int unsigned TIMER_SRC  = 19,
   parameter logic [DATA_W-1:0] RSVD_MASK = 32'h0FA2007F,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned REMAP_BIT  = 14
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC-1:0]        dev_irq,
   input  logic [NCPU-1:0]        tmr_irq,
   input  logic                   bus_master,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   bus_wr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   output logic [NCPU*(2**LVL_W-1)-1:0] lvl_out
);
   localparam int unsigned NLVL  = 2**LVL_W;
   localparam int unsigned OUT_W = NLVL - 1;
   localparam int unsigned CPU_W = $clog2(NCPU);
   localparam logic [DATA_W-1:0] VALID    = ~RSVD_MASK;
   localparam logic [DATA_W-1:0] GDIS     = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] TMR_MBIT = {{(DATA_W-1){1'b0}}, 1'b1} << TIMER_SRC;
   localparam logic [NLVL-1:0]   TMR_LOH  = {{(NLVL-1){1'b0}}, 1'b1} << LVL_MAP[TIMER_SRC*LVL_W +: LVL_W];

   if (NSRC != DATA_W) begin : g_bad_nsrc
      $error("NSRC must equal the bus width");
   end
   if (NCPU < 2 || (2**CPU_W) != NCPU) begin : g_bad_ncpu
      $error("NCPU must be a power of two of at least 2");
   end
   if (TIMER_SRC >= NSRC) begin : g_bad_tmr
      $error("TIMER_SRC out of range");
   end
   if (2*NLVL != DATA_W || REMAP_BIT >= DATA_W-OUT_W) begin : g_bad_lvl
      $error("level width does not fit the software field");
   end
   if (PAGE_SHIFT + CPU_W > ADDR_W || PAGE_SHIFT < 5) begin : g_bad_addr
      $error("page field does not fit the address");
   end

   // edge capture of request lines
   logic [NSRC-1:0] dev_q, src_ok, dev_rise, dev_fall;
   logic [NCPU-1:0] tmr_q, tmr_rise, tmr_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_q <= '0;
         tmr_q <= '0;
      end else begin
         dev_q <= dev_irq;
         tmr_q <= tmr_irq;
      end
   end

   for (genvar j = 0; j < NSRC; j++) begin : g_srcok
      assign src_ok[j] = |LVL_MAP[j*LVL_W +: LVL_W];
   end

   assign dev_rise = dev_irq & ~dev_q & src_ok;
   assign dev_fall = ~dev_irq & dev_q & src_ok;
   assign tmr_rise = tmr_irq & ~tmr_q;
   assign tmr_fall = ~tmr_irq & tmr_q;

   // bus decode
   logic [CPU_W-1:0] pg;
   logic [2:0]       mw;
   logic [1:0]       cw;
   logic             m_wr, c_wr;

   assign pg   = bus_addr[PAGE_SHIFT +: CPU_W];
   assign mw   = bus_addr[4:2];
   assign cw   = bus_addr[3:2];
   assign m_wr = bus_wr & bus_master;
   assign c_wr = bus_wr & ~bus_master;

   // shared registers
   logic [DATA_W-1:0] mpend, mdis, m_set, m_clr;
   logic [CPU_W-1:0]  tgt;

   assign m_set = dev_rise | ((|tmr_rise) ? TMR_MBIT : '0);
   assign m_clr = dev_fall | ((|tmr_fall) ? TMR_MBIT : '0);

   mpir_master_regs #(.DATA_W(DATA_W), .CPU_W(CPU_W), .VALID(VALID)) u_master (
      .clk(clk), .rst_n(rst_n), .src_set(m_set), .src_clr(m_clr),
      .ena_wr(m_wr && mw == MW_ENA), .mask_wr(m_wr && mw == MW_MASK),
      .tgt_wr(m_wr && mw == MW_TGT), .wdata(bus_wdata),
      .pend(mpend), .dis(mdis), .tgt(tgt));

   // per-processor pending registers
   logic [NLVL-1:0]        rise_lvl, fall_lvl;
   logic [NCPU*DATA_W-1:0] cpu_pend_flat;

   mpir_lvl_map #(.NSRC(NSRC), .LVL_W(LVL_W), .NLVL(NLVL), .LVL_MAP(LVL_MAP))
      u_rise_map (.src(dev_rise), .lvl(rise_lvl));
   mpir_lvl_map #(.NSRC(NSRC), .LVL_W(LVL_W), .NLVL(NLVL), .LVL_MAP(LVL_MAP))
      u_fall_map (.src(dev_fall), .lvl(fall_lvl));

   for (genvar i = 0; i < NCPU; i++) begin : g_cpu
      logic            hit, pg_hit;
      logic [NLVL-1:0] s_l, c_l;
      assign hit    = (int'(tgt) == i);
      assign pg_hit = c_wr && (int'(pg) == i);
      assign s_l    = (hit ? rise_lvl : '0) | (tmr_rise[i] ? TMR_LOH : '0);
      assign c_l    = (hit ? fall_lvl : '0) | (tmr_fall[i] ? TMR_LOH : '0);

      mpir_cpu_pend #(.DATA_W(DATA_W), .OUT_W(OUT_W), .REMAP_BIT(REMAP_BIT)) u_pend (
         .clk(clk), .rst_n(rst_n),
         .lvl_set({{(DATA_W-NLVL){1'b0}}, s_l[NLVL-1:1], 1'b0}),
         .lvl_clr({{(DATA_W-NLVL){1'b0}}, c_l[NLVL-1:1], 1'b0}),
         .sw_set_wr(pg_hit && cw == CW_SWSET),
         .sw_clr_wr(pg_hit && cw == CW_SWCLR),
         .wdata(bus_wdata),
         .pend(cpu_pend_flat[i*DATA_W +: DATA_W]));
   end

   // read path
   always_comb begin
      bus_rdata = '0;
      if (bus_master) begin
         case (mw)
            MW_PEND: bus_rdata = mpend & ~GDIS;
            MW_DIS:  bus_rdata = mdis & VALID;
            MW_TGT:  bus_rdata = {{(DATA_W-CPU_W){1'b0}}, tgt};
            default: bus_rdata = '0;
         endcase
      end else if (cw == CW_PEND && bus_addr[4] == 1'b0) begin
         bus_rdata = cpu_pend_flat[int'(pg)*DATA_W +: DATA_W];
      end
   end

   mpir_route #(.NCPU(NCPU), .DATA_W(DATA_W), .LVL_W(LVL_W), .NLVL(NLVL), .OUT_W(OUT_W),
                .CPU_W(CPU_W), .LVL_MAP(LVL_MAP)) u_route (
      .mpend(mpend), .mdis(mdis), .tgt(tgt),
      .cpu_pend_flat(cpu_pend_flat), .lvl_out(lvl_out));

   logic unused_bits;
   assign unused_bits = ^{bus_addr[1:0], bus_addr[PAGE_SHIFT-1:5], rise_lvl[0], fall_lvl[0]};
endmodule

// File: rtl/mpir_chk.sv
module mpir_chk #(
   parameter int unsigned NCPU       = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned OUT_W      = 15,
   parameter int unsigned CPU_W      = 4,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter logic [DATA_W-1:0] VALID = '1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_master,
   input logic                   bus_wr,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [DATA_W-1:0]      bus_wdata,
   input logic [DATA_W-1:0]      mpend,
   input logic [DATA_W-1:0]      mdis,
   input logic [NCPU*DATA_W-1:0] cpu_pend_flat,
   input logic [NCPU*OUT_W-1:0]  lvl_out
);
   localparam logic [DATA_W-1:0] SW_MASK = {{OUT_W{1'b1}}, {(DATA_W-OUT_W){1'b0}}};

   p_rsvd_dis_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mdis & ~VALID) == ~VALID);

   p_mask_clears_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_master && bus_addr[4:2] == 3'd3)
      |=> (mpend & $past(bus_wdata & VALID)) == '0);

   p_ena_clears_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_master && bus_addr[4:2] == 3'd2)
      |=> (mdis & $past(bus_wdata & VALID)) == '0);

   for (genvar i = 0; i < NCPU; i++) begin : g_chk
      p_gdis_r7: assert property (@(posedge clk) disable iff (!rst_n)
         mdis[DATA_W-1] |->
         lvl_out[i*OUT_W +: OUT_W] == cpu_pend_flat[i*DATA_W + DATA_W-1 -: OUT_W]);

      p_swset_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && !bus_master && int'(bus_addr[PAGE_SHIFT +: CPU_W]) == i
          && bus_addr[3:2] == 2'd2)
         |=> (cpu_pend_flat[i*DATA_W +: DATA_W] & $past(bus_wdata & SW_MASK))
             == $past(bus_wdata & SW_MASK));
   end
endmodule

bind mp_irq_router mpir_chk #(
   .NCPU(NCPU), .DATA_W(mpir_pkg::DATA_W), .OUT_W(OUT_W), .CPU_W(CPU_W),
   .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .VALID(VALID)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_master(bus_master), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mpend(mpend), .mdis(mdis),
   .cpu_pend_flat(cpu_pend_flat), .lvl_out(lvl_out));

// File: tb/test_mp_irq_router.sv
module test_mp_irq_router;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   dev_irq = '0;
   logic [15:0]   tmr_irq = '0;
   logic          bus_master = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [239:0]  lvl_out;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] rd;

   always #5 clk = ~clk;

   mp_irq_router i_mp_irq_router (
      .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .tmr_irq(tmr_irq),
      .bus_master(bus_master), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvl_out(lvl_out));

   // level table in the DUT: source j -> level j mod 16
   typedef struct packed {
      logic [31:0] dev;
      logic [14:0] exp;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{32'h0000_0000, 15'h0000},   // nothing raised
      '{32'h0000_0400, 15'h0200},   // src 10 -> level 10
      '{32'h0010_0400, 15'h0208},   // plus src 20 -> level 4
      '{32'h0001_0000, 15'h0000},   // src 16 has level 0: ignored
      '{32'h0000_0020, 15'h0000},   // src 5 reserved, stays disabled
      '{32'h0080_0080, 15'h0040},   // src 7 level 7, src 23 reserved
      '{32'h6000_0000, 15'h3000},   // src 29,30 -> levels 13,14
      '{32'h8000_0000, 15'h4000},   // src 31 -> level 15
      '{32'h0000_0000, 15'h0000}
   };

   function automatic logic [31:0] lv(input int c);
      return {17'b0, lvl_out[c*15 +: 15]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic mwrite(input logic [2:0] w, input logic [31:0] d);
      bus_master = 1'b1; bus_addr = {11'b0, w, 2'b0}; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic cwrite(input logic [3:0] c, input logic [1:0] w, input logic [31:0] d);
      bus_master = 1'b0; bus_addr = {c, 8'b0, w, 2'b0}; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic mread(input logic [2:0] w, output logic [31:0] d);
      bus_master = 1'b1; bus_addr = {11'b0, w, 2'b0};
      #1 d = bus_rdata;
   endtask

   task automatic cread(input logic [3:0] c, input logic [1:0] w, output logic [31:0] d);
      bus_master = 1'b0; bus_addr = {c, 8'b0, w, 2'b0};
      #1 d = bus_rdata;
   endtask

   task automatic drive_dev(input logic [31:0] v);
      dev_irq = v;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R3: reset state
      chk("R3 out cpu0", lv(0), 0);
      chk("R3 out cpu15", lv(15), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mread(3'd0, rd); chk("R3 pend", rd, 0);
      mread(3'd1, rd); chk("R3 dis", rd, 0);
      mread(3'd4, rd); chk("R3 tgt", rd, 0);
      cread(4'd0, 2'd0, rd); chk("R3 cpu pend", rd, 0);

      // R5/R6/R2 vector walk with target 0, R11 latency
      for (int k = 0; k < 9; k++) begin
         logic [31:0] prev;
         prev = lv(0);
         dev_irq = VECS[k].dev;
         #1 chk("R11 before edge", lv(0), prev);
         @(posedge clk); @(negedge clk);
         chk("R6 vector cpu0", lv(0), {17'b0, VECS[k].exp});
         chk("R6 vector cpu1", lv(1), 0);
      end

      // R5: shared and per-processor pending
      drive_dev(32'h2001_0000);
      mread(3'd0, rd); chk("R5 shared pend", rd, 32'h2000_0000);
      cread(4'd0, 2'd0, rd); chk("R5 cpu0 pend", rd, 32'h0000_2000);
      drive_dev(32'h0);
      mread(3'd0, rd); chk("R5 shared clr", rd, 0);
      cread(4'd0, 2'd0, rd); chk("R5 cpu0 clr", rd, 0);

      // R6: target selection
      mwrite(3'd4, 32'h13);
      mread(3'd4, rd); chk("R6 tgt 4 bits", rd, 3);
      drive_dev(32'h0000_0200);
      chk("R6 cpu3", lv(3), 32'h100);
      chk("R6 cpu0 quiet", lv(0), 0);
      cread(4'd3, 2'd0, rd); chk("R6 cpu3 pend", rd, 32'h200);
      mwrite(3'd4, 32'h5);
      chk("R6 cpu5", lv(5), 32'h100);
      chk("R6 cpu3 off", lv(3), 0);

      // R4: disable and enable
      mwrite(3'd3, 32'h200);
      chk("R4 masked out", lv(5), 0);
      mread(3'd0, rd); chk("R4 pend cleared", rd, 0);
      mread(3'd1, rd); chk("R4 dis set", rd, 32'h200);
      drive_dev(32'h0);
      drive_dev(32'h200);
      mread(3'd0, rd); chk("R4 pend while disabled", rd, 32'h200);
      chk("R4 no out while disabled", lv(5), 0);
      mwrite(3'd2, 32'h200);
      chk("R4 enabled out", lv(5), 32'h100);
      mread(3'd1, rd); chk("R4 dis cleared", rd, 0);

      // R2: valid mask
      mwrite(3'd3, 32'hFFFF_FFFF);
      mread(3'd1, rd); chk("R2 dis read", rd, 32'hF05D_FF80);
      mread(3'd0, rd); chk("R2 pend all cleared", rd, 0);
      mwrite(3'd2, 32'hFFFF_FFFF);
      mread(3'd1, rd); chk("R2 dis cleared", rd, 0);
      drive_dev(32'h0);
      drive_dev(32'h200);
      chk("R2 reenabled", lv(5), 32'h100);

      // R7: global disable
      cwrite(4'd5, 2'd2, 32'h0010_0000);
      chk("R7 dev+sw", lv(5), 32'h108);
      mwrite(3'd3, 32'h8000_0000);
      chk("R7 only sw", lv(5), 32'h008);
      mread(3'd1, rd); chk("R7 dis bit31", rd, 32'h8000_0000);
      mwrite(3'd2, 32'h8000_0000);
      chk("R7 restored", lv(5), 32'h108);

      // R1: decode
      drive_dev(32'h8000_0200);
      mread(3'd0, rd); chk("R1 bit31 hidden", rd, 32'h200);
      chk("R1 level15 out", lv(5), 32'h4108);
      mread(3'd5, rd); chk("R1 undef m5", rd, 0);
      mread(3'd2, rd); chk("R1 write-only m2", rd, 0);
      mwrite(3'd6, 32'hFFFF_FFFF);
      mread(3'd1, rd); chk("R1 m6 write ignored dis", rd, 0);
      mread(3'd4, rd); chk("R1 m6 write ignored tgt", rd, 5);
      cread(4'd5, 2'd3, rd); chk("R1 undef c3", rd, 0);
      cread(4'd5, 2'd1, rd); chk("R1 write-only c1", rd, 0);
      cwrite(4'd5, 2'd3, 32'hFFFF_FFFF);
      cread(4'd5, 2'd0, rd); chk("R1 c3 write ignored", rd, 32'h0010_8200);

      // R8: software set
      cwrite(4'd6, 2'd2, 32'hFFFF_FFFF);
      cread(4'd6, 2'd0, rd); chk("R8 sw pend", rd, 32'hFFFE_0000);
      chk("R8 sw out", lv(6), 32'h7FFF);
      chk("R8 other page", lv(5), 32'h4108);

      // R9: software clear with remap
      cwrite(4'd6, 2'd1, 32'h0000_4000);
      cread(4'd6, 2'd0, rd); chk("R9 remap clears 31", rd, 32'h7FFE_0000);
      chk("R9 remap out", lv(6), 32'h3FFF);
      cwrite(4'd6, 2'd1, 32'h0002_0000);
      cread(4'd6, 2'd0, rd); chk("R9 clr bit17", rd, 32'h7FFC_0000);
      chk("R9 clr out", lv(6), 32'h3FFE);
      cwrite(4'd6, 2'd1, 32'h0000_BFFF);
      cread(4'd6, 2'd0, rd); chk("R9 low bits ignored", rd, 32'h7FFC_0000);

      // R10: timer
      tmr_irq[2] = 1'b1;
      @(posedge clk); @(negedge clk);
      mread(3'd0, rd); chk("R10 shared bit", rd, 32'h0008_0200);
      cread(4'd2, 2'd0, rd); chk("R10 cpu2 pend", rd, 32'h8);
      chk("R10 routed to target", lv(5), 32'h410C);
      chk("R10 cpu2 out", lv(2), 0);
      tmr_irq[2] = 1'b0;
      @(posedge clk); @(negedge clk);
      cread(4'd2, 2'd0, rd); chk("R10 cpu2 clr", rd, 0);
      mread(3'd0, rd); chk("R10 shared clr", rd, 32'h200);
      chk("R10 out clr", lv(5), 32'h4108);

      // R3: reset again
      drive_dev(32'h0);
      rst_n = 1'b0;
      #1 chk("R3 async out", lv(6), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mread(3'd1, rd); chk("R3 dis after reset", rd, 0);
      mread(3'd4, rd); chk("R3 tgt after reset", rd, 0);
      cread(4'd6, 2'd0, rd); chk("R3 cpu6 after reset", rd, 0);
      chk("R3 out after reset", lv(5), 0);

      finish_run();
   end
endmodule